// File: doc/BRIEF.md
# Stepper phase step sequencer

This block sits between the slow control pins of a microstepping stepper driver and its current-shaping logic. It takes four asynchronous control levels: a step clock, a direction select, a return-to-origin request and a drive enable. It also takes a fifth level that picks the step-edge mode. Each pin is brought into the system-clock domain and deglitched. The block then keeps an up/down excitation-phase index that later stages use to look up winding currents.

With the mode pin high, only rising step-clock edges move the phase. With it low, both edges move it, which gives two steps per step-clock period. The direction pin picks clockwise (count up) or counterclockwise (count down), modulo a parameterised number of phase positions. A rising edge on the return pin snaps the phase to the origin. Driving the enable pin low enters hold: the four winding-drive enables go inactive and every other part of the block freezes until enable returns high or reset is applied. Every pin that is left open reads as high.

Top module: `stepseq_top`

## Requirements
- R1: With the filtered mode level high (1), each accepted rising step edge moves the phase by one position, and falling step edges move nothing.
- R2: With the filtered mode level low (0), each accepted rising and each accepted falling step edge moves the phase by one position.
- R3: With the filtered direction level 0 (clockwise) the phase counts up, and with level 1 (counterclockwise) it counts down. The phase always stays in 0..PHASE_STEPS-1, going from PHASE_STEPS-1 to 0 when counting up and from 0 to PHASE_STEPS-1 when counting down.
- R4: An accepted rising edge of the return level sets the phase to 0 and wins over a step event in the same cycle. A falling edge of the return level has no effect.
- R5: While the filtered enable level is 0, `hold_o` is 1 and `drive_en_o` is 4'b0000. The phase does not change, and step, direction, return and mode pin activity is ignored. While that level is 1, `hold_o` is 0 and `drive_en_o` is 4'b1111.
- R6: A pin level is accepted only after it has been seen for FILT_LEN consecutive system-clock samples at the synchroniser output. Shorter pulses leave the phase unchanged.
- R7: A pin change that is held long enough reaches `phase_o` SYNC_STAGES + FILT_LEN + 1 clock edges after the first edge that samples it.
- R8: Synchronous reset sets the phase to 0 and sets every synchroniser and filtered level to 1, so after reset the block is enabled (`drive_en_o` = 4'b1111, `hold_o` = 0) and in single-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_pin_i | input | 1 | Asynchronous step clock |
| dir_pin_i | input | 1 | Asynchronous direction: 0 clockwise, 1 counterclockwise |
| ret_pin_i | input | 1 | Asynchronous return-to-origin request, acts on its rising edge |
| mode_pin_i | input | 1 | Asynchronous edge mode: 1 rising edges only, 0 both edges |
| ena_pin_i | input | 1 | Asynchronous enable: 1 run, 0 hold |
| phase_o | output | $clog2(PHASE_STEPS) | Excitation phase index |
| drive_en_o | output | 4 | Enables for the four winding drives |
| hold_o | output | 1 | High while the block is in hold |

## Verification
The bench builds the block with PHASE_STEPS = 12 and FILT_LEN = 3. The twelve-position ring is not a power of two, so wrapping in both directions exercises the explicit compare rather than a natural overflow, and it is reached within a handful of step pulses. A filter length of three separates a two-sample glitch from an accepted level. It also keeps the full pin-to-phase delay at six cycles, so edge modes, return, hold entry and hold exit all fit in a short run that is compared against the reference model on every clock.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    // Index of each control input in the filter bank
    typedef enum int unsigned {
        IN_STEP = 0,
        IN_DIR  = 1,
        IN_RET  = 2,
        IN_MODE = 3,
        IN_ENA  = 4
    } ctrl_in_e;

    localparam int unsigned NUM_CTRL_IN  = 5;
    localparam int unsigned NUM_DRIVE    = 4;
    localparam logic        PIN_IDLE_LVL = 1'b1;

endpackage

// File: rtl/stepseq_deglitch.sv
module stepseq_deglitch #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4,
    parameter logic        RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic freeze_i,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned CW       = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          run;
        logic                   level;
        logic                   rise;
        logic                   fall;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic       sampled;

    assign sampled = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!freeze_i) begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
            if (sampled != st_q.level) begin
                if (st_q.run == RUN_LAST) begin
                    st_d.level = sampled;
                    st_d.run   = '0;
                    st_d.rise  = sampled;
                    st_d.fall  = ~sampled;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sync  <= {SYNC_STAGES{RESET_LEVEL}};
            st_q.run   <= '0;
            st_q.level <= RESET_LEVEL;
            st_q.rise  <= 1'b0;
            st_q.fall  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign rise_o  = st_q.rise;
    assign fall_o  = st_q.fall;

    // R6: an accepted level always equals the synchroniser output one edge earlier
    assert_level_from_sync_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.level != $past(st_q.level)) |-> (st_q.level == $past(sampled)));

    // R5: a frozen filter keeps its accepted level
    assert_frozen_level_R5: assert property (@(posedge clk) disable iff (rst)
        freeze_i |=> (st_q.level == $past(st_q.level)));

    // R6: an edge flag only follows a level change
    assert_edge_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (rise_o || fall_o) |-> (st_q.level != $past(st_q.level)));

endmodule

// File: rtl/stepseq_step_select.sv
module stepseq_step_select (
    input  logic rise_i,
    input  logic fall_i,
    input  logic single_edge_i,
    output logic advance_o
);

    always_comb begin
        advance_o = rise_i;
        if (!single_edge_i && fall_i) begin
            advance_o = 1'b1;
        end
    end

endmodule

// File: rtl/stepseq_phase_counter.sv
module stepseq_phase_counter #(
    parameter int unsigned PHASE_STEPS = 64,
    parameter int unsigned PW          = $clog2(PHASE_STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          origin_i,
    input  logic          advance_i,
    input  logic          ccw_i,
    output logic [PW-1:0] phase_o
);

    localparam logic [PW-1:0] PH_LAST = PW'(PHASE_STEPS - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold_i) begin
            if (origin_i) begin
                st_d.phase = '0;
            end else if (advance_i) begin
                if (ccw_i) begin
                    st_d.phase = (st_q.phase == '0) ? PH_LAST : st_q.phase - 1'b1;
                end else begin
                    st_d.phase = (st_q.phase == PH_LAST) ? '0 : st_q.phase + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    // R3: phase never leaves the ring
    assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        phase_o <= PH_LAST);

    // R4: a return event lands on the origin
    assert_return_origin_R4: assert property (@(posedge clk) disable iff (rst)
        (origin_i && !hold_i) |=> (phase_o == '0));

    // R5: hold freezes the phase
    assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (phase_o == $past(phase_o)));

    // R3: clockwise step moves up one position with wrap
    assert_cw_step_R3: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !origin_i && !hold_i && !ccw_i) |=>
        (phase_o == (($past(phase_o) == PH_LAST) ? '0 : $past(phase_o) + 1'b1)));

    // R3: counterclockwise step moves down one position with wrap
    assert_ccw_step_R3: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !origin_i && !hold_i && ccw_i) |=>
        (phase_o == (($past(phase_o) == '0) ? PH_LAST : $past(phase_o) - 1'b1)));

    // R1: no movement without an event
    assert_idle_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (!advance_i && !origin_i) |=> (phase_o == $past(phase_o)));

endmodule

// File: rtl/stepseq_top.sv
module stepseq_top #(
    parameter int unsigned PHASE_STEPS = 64,
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PW         = $clog2(PHASE_STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_pin_i,
    input  logic          dir_pin_i,
    input  logic          ret_pin_i,
    input  logic          mode_pin_i,
    input  logic          ena_pin_i,
    output logic [PW-1:0] phase_o,
    output logic [3:0]    drive_en_o,
    output logic          hold_o
);

    import stepseq_pkg::*;

    logic [NUM_CTRL_IN-1:0] pins;
    logic [NUM_CTRL_IN-1:0] lvl;
    logic [NUM_CTRL_IN-1:0] rise;
    logic [NUM_CTRL_IN-1:0] fall;
    logic                   hold;
    logic                   advance;

    assign pins[IN_STEP] = step_pin_i;
    assign pins[IN_DIR]  = dir_pin_i;
    assign pins[IN_RET]  = ret_pin_i;
    assign pins[IN_MODE] = mode_pin_i;
    assign pins[IN_ENA]  = ena_pin_i;

    assign hold = ~lvl[IN_ENA];

    for (genvar gi = 0; gi < NUM_CTRL_IN; gi++) begin : g_filt
        logic frz;
        if (gi == int'(IN_ENA)) begin : g_free
            assign frz = 1'b0;
        end else begin : g_gated
            assign frz = hold;
        end
        stepseq_deglitch #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RESET_LEVEL (PIN_IDLE_LVL)
        ) i_flt (
            .clk      (clk),
            .rst      (rst),
            .freeze_i (frz),
            .pin_i    (pins[gi]),
            .level_o  (lvl[gi]),
            .rise_o   (rise[gi]),
            .fall_o   (fall[gi])
        );
    end

    stepseq_step_select i_sel (
        .rise_i        (rise[IN_STEP]),
        .fall_i        (fall[IN_STEP]),
        .single_edge_i (lvl[IN_MODE]),
        .advance_o     (advance)
    );

    stepseq_phase_counter #(
        .PHASE_STEPS (PHASE_STEPS),
        .PW          (PW)
    ) i_cnt (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold),
        .origin_i  (rise[IN_RET]),
        .advance_i (advance),
        .ccw_i     (lvl[IN_DIR]),
        .phase_o   (phase_o)
    );

    assign drive_en_o = hold ? '0 : {NUM_DRIVE{1'b1}};
    assign hold_o     = hold;

    // R2: in both-edge mode a falling step event becomes a phase move
    assert_both_edges_R2: assert property (@(posedge clk) disable iff (rst)
        (fall[IN_STEP] && !lvl[IN_MODE] && !hold && !rise[IN_RET]) |=>
        (phase_o != $past(phase_o)));

    // R1: in single-edge mode a lone falling step event moves nothing
    assert_single_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (fall[IN_STEP] && lvl[IN_MODE] && !rise[IN_RET]) |=>
        (phase_o == $past(phase_o)));

endmodule

// File: tb/test_stepseq_top.sv
`timescale 1ns/1ps
module test_stepseq_top;

    localparam int N  = 12;
    localparam int K  = 3;
    localparam int PW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step_pin = 1'b1;
    logic          dir_pin  = 1'b1;
    logic          ret_pin  = 1'b1;
    logic          mode_pin = 1'b1;
    logic          ena_pin  = 1'b1;
    logic [PW-1:0] phase;
    logic [3:0]    drive_en;
    logic          hold;

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    string cur_req = "R8";

    always #2 clk = ~clk;

    stepseq_top #(.PHASE_STEPS(N), .FILT_LEN(K), .SYNC_STAGES(2)) i_stepseq_top (
        .clk        (clk),
        .rst        (rst),
        .step_pin_i (step_pin),
        .dir_pin_i  (dir_pin),
        .ret_pin_i  (ret_pin),
        .mode_pin_i (mode_pin),
        .ena_pin_i  (ena_pin),
        .phase_o    (phase),
        .drive_en_o (drive_en),
        .hold_o     (hold)
    );

    // Behavioural reference: 0 step, 1 dir, 2 return, 3 mode, 4 enable
    int m_s0[5], m_s1[5], m_run[5], m_lvl[5], m_rise[5], m_fall[5];
    int m_ph;

    function automatic int pin_of(int i);
        case (i)
            0: return int'(step_pin);
            1: return int'(dir_pin);
            2: return int'(ret_pin);
            3: return int'(mode_pin);
            default: return int'(ena_pin);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0;
            for (int i = 0; i < 5; i++) begin
                m_s0[i] = 1; m_s1[i] = 1; m_run[i] = 0;
                m_lvl[i] = 1; m_rise[i] = 0; m_fall[i] = 0;
            end
        end else begin
            bit in_hold;
            in_hold = (m_lvl[4] == 0);
            if (!in_hold) begin
                if (m_rise[2] != 0) m_ph = 0;
                else if (m_rise[0] != 0 || (m_fall[0] != 0 && m_lvl[3] == 0))
                    m_ph = (m_lvl[1] != 0) ? (m_ph + N - 1) % N : (m_ph + 1) % N;
            end
            for (int i = 0; i < 5; i++) begin
                m_rise[i] = 0;
                m_fall[i] = 0;
                if (i == 4 || !in_hold) begin
                    if (m_s1[i] != m_lvl[i]) begin
                        if (m_run[i] == K - 1) begin
                            m_lvl[i] = m_s1[i];
                            m_run[i] = 0;
                            if (m_s1[i] != 0) m_rise[i] = 1; else m_fall[i] = 1;
                        end else begin
                            m_run[i] = m_run[i] + 1;
                        end
                    end else begin
                        m_run[i] = 0;
                    end
                    m_s1[i] = m_s0[i];
                    m_s0[i] = pin_of(i);
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Cycle compare against the model (R7 latency is covered here)
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk({cur_req, " phase R7"}, int'(phase), m_ph);
            chk({cur_req, " drive"}, int'(drive_en), (m_lvl[4] != 0) ? 15 : 0);
            chk({cur_req, " hold"}, int'(hold), (m_lvl[4] != 0) ? 0 : 1);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual %0d expected below 100000 cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_pulses(int n);
        for (int p = 0; p < n; p++) begin
            step_pin = 1'b0; wait_cyc(8);
            step_pin = 1'b1; wait_cyc(8);
        end
    endtask

    initial begin
        dir_pin = 1'b0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        chk("R8 reset phase", int'(phase), 0);
        chk("R8 reset drive", int'(drive_en), 15);
        chk("R8 reset hold", int'(hold), 0);

        cur_req = "R1";
        step_pulses(5);
        chk("R1 rising only", int'(phase), 5);

        cur_req = "R3";
        step_pulses(7);
        chk("R3 up wrap", int'(phase), 0);
        dir_pin = 1'b1; wait_cyc(8);
        step_pulses(2);
        chk("R3 down wrap", int'(phase), 10);

        cur_req = "R2";
        mode_pin = 1'b0; wait_cyc(8);
        step_pulses(2);
        chk("R2 both edges", int'(phase), 6);

        cur_req = "R6";
        step_pin = 1'b0; wait_cyc(2);
        step_pin = 1'b1; wait_cyc(10);
        chk("R6 glitch ignored", int'(phase), 6);

        cur_req = "R4";
        ret_pin = 1'b0; wait_cyc(8);
        chk("R4 falling return no effect", int'(phase), 6);
        ret_pin = 1'b1; wait_cyc(8);
        chk("R4 return origin", int'(phase), 0);

        cur_req = "R2";
        dir_pin = 1'b0; wait_cyc(8);
        step_pulses(1);
        chk("R2 two steps per period", int'(phase), 2);

        cur_req = "R5";
        ena_pin = 1'b0; wait_cyc(10);
        chk("R5 hold drive off", int'(drive_en), 0);
        chk("R5 hold flag", int'(hold), 1);
        dir_pin = 1'b1; mode_pin = 1'b1;
        step_pulses(3);
        ret_pin = 1'b0; wait_cyc(8);
        ret_pin = 1'b1; wait_cyc(8);
        chk("R5 phase frozen", int'(phase), 2);
        dir_pin = 1'b0; mode_pin = 1'b0; wait_cyc(4);
        ena_pin = 1'b1; wait_cyc(10);
        chk("R5 resume drive", int'(drive_en), 15);
        chk("R5 resume phase", int'(phase), 2);
        step_pulses(1);
        chk("R5 stepping after hold", int'(phase), 4);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule